// File: doc/BRIEF.md
# FIR-Prefiltered Memory Polynomial Predistorter

This block predistorts a stream of complex baseband samples before they go to a DAC path. Each accepted sample first passes through a linear complex FIR prefilter. The prefilter corrects the linear memory distortion that a wideband amplifier shows at low drive. The prefilter result `u` then drives a memory polynomial. That polynomial sums complex-weighted terms `u[n-q]·|u[n-q]|^k` over memory lags `q = 0..MEM_DEPTH` and over even powers `k = 0..NL_ORDER`.

The even envelope powers are built from `I²+Q²` and from repeated products of that value, so no square root is needed. The FIR taps and the polynomial weights are complex registers loaded through a one-cycle write port.

When the prefilter holds a single unit tap, the block reduces to a plain memory polynomial predistorter. Samples enter and leave with a single valid strobe and no backpressure. The delay histories advance once per accepted sample, so idle cycles between samples do not disturb the filter or the polynomial memory.

Top module: `fmp_predistorter`

## Requirements
- R1: Reset drives `outVld` low and `outI`/`outQ` to zero. It loads the identity setting: FIR tap 0 = 1.0, polynomial weight (k=0, q=0) = 1.0, every other coefficient zero. After reset, each output sample equals its input sample.
- R2: `outVld` equals `inVld` delayed by exactly 3 clock cycles. Output samples come out in input order, one per accepted input. `outI`/`outQ` hold their value in cycles where `outVld` is low.
- R3: The prefilter output is `u[n] = RS(Σ_{l=0..FIR_ORDER} h_l·x[n-l], 14)` using a complex multiply. Here `x[n-l]` is the l-th previously accepted sample, so the history advances only on accepted samples.
- R4: The squared envelope is `p1 = RS(uI²+uQ², DW-1)`. Higher even powers are `p_j = RS(p_{j-1}·p1, DW-1)` for j ≥ 2. Power index j stands for k = 2j.
- R5: The basis term for power index j is `u` when j = 0, and `RS(u·p_j, DW-1)` per component otherwise. The output is `RS(Σ_{j,q} a_{2j,q}·b_j[n-q], 14)` with a complex multiply, where `b_j[n-q]` is the basis set of the q-th previous accepted sample.
- R6: `RS(v, s)` adds 2^(s-1), shifts right arithmetically by s, and clamps to [-2^(DW-1), 2^(DW-1)-1]. Full-scale results clamp and never wrap.
- R7: Coefficient words are signed CW-bit values with 14 fraction bits. Addresses map as follows: address l (0..FIR_ORDER) writes tap h_l. Address `FIR_ORDER+1 + j·(MEM_DEPTH+1) + q` writes weight a_{2j,q}. A write to any higher address changes nothing.
- R8: A coefficient written while no sample is in flight applies to every later sample.
- R9: With the prefilter set to a single unit tap, the output equals that of a plain memory polynomial applied to the raw input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inVld | input | 1 | Input sample strobe |
| inI | input | DW | Input in-phase sample, signed, DW-1 fraction bits |
| inQ | input | DW | Input quadrature sample, signed |
| cfgWe | input | 1 | Coefficient write enable |
| cfgAddr | input | AW | Coefficient address |
| cfgRe | input | CW | Coefficient real part, signed, 14 fraction bits |
| cfgIm | input | CW | Coefficient imaginary part, signed |
| outVld | output | 1 | Output sample strobe |
| outI | output | DW | Predistorted in-phase sample |
| outQ | output | DW | Predistorted quadrature sample |

## Verification
The bench drives full-scale inputs against weights near ±2. A design that wrapped instead of clamping would flip the output sign there. Bursts with irregular gaps between samples expose a design whose histories shift on every clock: its lagged terms would read stale or zero data. The bench programs lag and higher-power weights separately, with the unit prefilter and then with a dispersive one. This catches a swapped address decode or a polynomial fed from the raw input instead of the filter output. Writes to unmapped addresses are followed by samples whose expected values assume unchanged weights.

// File: rtl/fmp_pkg.sv
package fmp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic stgA;   // sample accepted: FIR stage loads
    logic stgB;   // power / basis stage loads
    logic stgC;   // accumulation stage loads, basis history shifts
    logic firWe;  // write to a FIR tap
    logic polyWe; // write to a polynomial weight
  } fmp_strb_t;
endpackage

// File: rtl/fmp_rndsat.sv
module fmp_rndsat #(
  parameter int IW = 32,
  parameter int SH = 14,
  parameter int OW = 12
) (
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] dout
);
  localparam int MAXI = 2**(OW-1) - 1;
  localparam logic signed [IW:0] MAXV = (IW+1)'(MAXI);
  localparam logic signed [IW:0] MINV = -MAXV - 1;
  localparam logic signed [IW:0] HALF = (IW+1)'(2**(SH-1));

  logic signed [IW:0] ext, sum, shf;

  always_comb begin
    ext = {din[IW-1], din};
    sum = ext + HALF;
    shf = sum >>> SH;
    if (shf > MAXV)      dout = OW'(MAXV);
    else if (shf < MINV) dout = OW'(MINV);
    else                 dout = OW'(shf);
  end
endmodule

// File: rtl/fmp_ctrl.sv
module fmp_ctrl
  import fmp_pkg::*;
#(
  parameter int NTAPS = 3,
  parameter int NCOEF = 12,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inVld,
  input  logic          cfgWe,
  input  logic [AW-1:0] cfgAddr,
  output fmp_strb_t     strb,
  output logic          outVld
);
  logic vld1, vld2;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld1   <= 1'b0;
      vld2   <= 1'b0;
      outVld <= 1'b0;
    end else begin
      vld1   <= inVld;
      vld2   <= vld1;
      outVld <= vld2;
    end
  end

  always_comb begin
    strb.stgA   = inVld;
    strb.stgB   = vld1;
    strb.stgC   = vld2;
    strb.firWe  = cfgWe && (int'(cfgAddr) < NTAPS);
    strb.polyWe = cfgWe && (int'(cfgAddr) >= NTAPS) && (int'(cfgAddr) < NCOEF);
  end
endmodule

// File: rtl/fmp_datapath.sv
module fmp_datapath
  import fmp_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CW    = 16,
  parameter int CFRAC = 14,
  parameter int L     = 2,   // FIR order, >= 1
  parameter int Q     = 2,   // memory depth, >= 1
  parameter int K     = 4,   // even nonlinearity order, >= 2
  parameter int AW    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  fmp_strb_t            strb,
  input  logic [AW-1:0]        cfgAddr,
  input  logic signed [CW-1:0] cfgRe,
  input  logic signed [CW-1:0] cfgIm,
  input  logic signed [DW-1:0] inI,
  input  logic signed [DW-1:0] inQ,
  output logic signed [DW-1:0] outI,
  output logic signed [DW-1:0] outQ
);
  localparam int NTAPS = L + 1;
  localparam int QD    = Q + 1;
  localparam int NP    = K / 2 + 1;
  localparam int ONE   = 2**CFRAC;
  localparam int FACC  = DW + CW + $clog2(2*NTAPS) + 1;
  localparam int OACC  = DW + CW + $clog2(2*NP*QD) + 1;
  localparam int SQW   = 2*DW + 1;
  localparam int PPW   = 2*DW;

  // coefficient bank
  logic signed [CW-1:0] hRe [NTAPS];
  logic signed [CW-1:0] hIm [NTAPS];
  logic signed [CW-1:0] aRe [NP][QD];
  logic signed [CW-1:0] aIm [NP][QD];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NTAPS; l++) begin
        hRe[l] <= (l == 0) ? CW'(ONE) : '0;
        hIm[l] <= '0;
      end
    end else if (strb.firWe) begin
      for (int l = 0; l < NTAPS; l++) begin
        if (int'(cfgAddr) == l) begin
          hRe[l] <= cfgRe;
          hIm[l] <= cfgIm;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NP; j++) begin
        for (int q = 0; q < QD; q++) begin
          aRe[j][q] <= (j == 0 && q == 0) ? CW'(ONE) : '0;
          aIm[j][q] <= '0;
        end
      end
    end else if (strb.polyWe) begin
      for (int j = 0; j < NP; j++) begin
        for (int q = 0; q < QD; q++) begin
          if (int'(cfgAddr) == NTAPS + j*QD + q) begin
            aRe[j][q] <= cfgRe;
            aIm[j][q] <= cfgIm;
          end
        end
      end
    end
  end

  // ---------------- stage A: complex FIR prefilter ----------------
  logic signed [DW-1:0]   xHistI [L];
  logic signed [DW-1:0]   xHistQ [L];
  logic signed [DW-1:0]   tapI   [NTAPS];
  logic signed [DW-1:0]   tapQ   [NTAPS];
  logic signed [FACC-1:0] firI, firQ;
  logic signed [DW-1:0]   uNxtI, uNxtQ, uI, uQ;

  always_comb begin
    tapI[0] = inI;
    tapQ[0] = inQ;
    for (int l = 1; l < NTAPS; l++) begin
      tapI[l] = xHistI[l-1];
      tapQ[l] = xHistQ[l-1];
    end
    firI = '0;
    firQ = '0;
    for (int l = 0; l < NTAPS; l++) begin
      firI = firI + FACC'(hRe[l]) * FACC'(tapI[l]) - FACC'(hIm[l]) * FACC'(tapQ[l]);
      firQ = firQ + FACC'(hRe[l]) * FACC'(tapQ[l]) + FACC'(hIm[l]) * FACC'(tapI[l]);
    end
  end

  fmp_rndsat #(.IW(FACC), .SH(CFRAC), .OW(DW)) u_rsFirI (.din(firI), .dout(uNxtI));
  fmp_rndsat #(.IW(FACC), .SH(CFRAC), .OW(DW)) u_rsFirQ (.din(firQ), .dout(uNxtQ));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < L; l++) begin
        xHistI[l] <= '0;
        xHistQ[l] <= '0;
      end
      uI <= '0;
      uQ <= '0;
    end else if (strb.stgA) begin
      xHistI[0] <= inI;
      xHistQ[0] <= inQ;
      for (int l = 1; l < L; l++) begin
        xHistI[l] <= xHistI[l-1];
        xHistQ[l] <= xHistQ[l-1];
      end
      uI <= uNxtI;
      uQ <= uNxtQ;
    end
  end

  // ---------------- stage B: even envelope powers and basis ----------------
  logic signed [SQW-1:0] sqSum;
  logic signed [DW-1:0]  pw    [1:NP-1];
  logic signed [DW-1:0]  bNxtI [1:NP-1];
  logic signed [DW-1:0]  bNxtQ [1:NP-1];

  always_comb sqSum = SQW'(uI) * SQW'(uI) + SQW'(uQ) * SQW'(uQ);

  fmp_rndsat #(.IW(SQW), .SH(DW-1), .OW(DW)) u_rsSq (.din(sqSum), .dout(pw[1]));

  for (genvar j = 1; j < NP; j++) begin : g_pow
    logic signed [PPW-1:0] bpI, bpQ;
    if (j >= 2) begin : g_chain
      logic signed [PPW-1:0] pp;
      assign pp = PPW'(pw[j-1]) * PPW'(pw[1]);
      fmp_rndsat #(.IW(PPW), .SH(DW-1), .OW(DW)) u_rsPow (.din(pp), .dout(pw[j]));
    end
    assign bpI = PPW'(uI) * PPW'(pw[j]);
    assign bpQ = PPW'(uQ) * PPW'(pw[j]);
    fmp_rndsat #(.IW(PPW), .SH(DW-1), .OW(DW)) u_rsBi (.din(bpI), .dout(bNxtI[j]));
    fmp_rndsat #(.IW(PPW), .SH(DW-1), .OW(DW)) u_rsBq (.din(bpQ), .dout(bNxtQ[j]));
  end

  logic signed [DW-1:0] basCurI [NP];
  logic signed [DW-1:0] basCurQ [NP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NP; j++) begin
        basCurI[j] <= '0;
        basCurQ[j] <= '0;
      end
    end else if (strb.stgB) begin
      basCurI[0] <= uI;
      basCurQ[0] <= uQ;
      for (int j = 1; j < NP; j++) begin
        basCurI[j] <= bNxtI[j];
        basCurQ[j] <= bNxtQ[j];
      end
    end
  end

  // ---------------- stage C: memory polynomial accumulation ----------------
  logic signed [DW-1:0]   bHistI [Q][NP];
  logic signed [DW-1:0]   bHistQ [Q][NP];
  logic signed [DW-1:0]   basAllI [QD][NP];
  logic signed [DW-1:0]   basAllQ [QD][NP];
  logic signed [OACC-1:0] accI, accQ;
  logic signed [DW-1:0]   oNxtI, oNxtQ;

  always_comb begin
    for (int j = 0; j < NP; j++) begin
      basAllI[0][j] = basCurI[j];
      basAllQ[0][j] = basCurQ[j];
    end
    for (int q = 1; q < QD; q++) begin
      for (int j = 0; j < NP; j++) begin
        basAllI[q][j] = bHistI[q-1][j];
        basAllQ[q][j] = bHistQ[q-1][j];
      end
    end
    accI = '0;
    accQ = '0;
    for (int j = 0; j < NP; j++) begin
      for (int q = 0; q < QD; q++) begin
        accI = accI + OACC'(aRe[j][q]) * OACC'(basAllI[q][j])
                    - OACC'(aIm[j][q]) * OACC'(basAllQ[q][j]);
        accQ = accQ + OACC'(aRe[j][q]) * OACC'(basAllQ[q][j])
                    + OACC'(aIm[j][q]) * OACC'(basAllI[q][j]);
      end
    end
  end

  fmp_rndsat #(.IW(OACC), .SH(CFRAC), .OW(DW)) u_rsOutI (.din(accI), .dout(oNxtI));
  fmp_rndsat #(.IW(OACC), .SH(CFRAC), .OW(DW)) u_rsOutQ (.din(accQ), .dout(oNxtQ));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int q = 0; q < Q; q++) begin
        for (int j = 0; j < NP; j++) begin
          bHistI[q][j] <= '0;
          bHistQ[q][j] <= '0;
        end
      end
      outI <= '0;
      outQ <= '0;
    end else if (strb.stgC) begin
      for (int j = 0; j < NP; j++) begin
        bHistI[0][j] <= basCurI[j];
        bHistQ[0][j] <= basCurQ[j];
      end
      for (int q = 1; q < Q; q++) begin
        for (int j = 0; j < NP; j++) begin
          bHistI[q][j] <= bHistI[q-1][j];
          bHistQ[q][j] <= bHistQ[q-1][j];
        end
      end
      outI <= oNxtI;
      outQ <= oNxtQ;
    end
  end
endmodule

// File: rtl/fmp_predistorter.sv
module fmp_predistorter
  import fmp_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CW    = 16,
  parameter int CFRAC = 14,
  parameter int L     = 2,
  parameter int Q     = 2,
  parameter int K     = 4,
  parameter int AW    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inVld,
  input  logic signed [DW-1:0] inI,
  input  logic signed [DW-1:0] inQ,
  input  logic                 cfgWe,
  input  logic [AW-1:0]        cfgAddr,
  input  logic signed [CW-1:0] cfgRe,
  input  logic signed [CW-1:0] cfgIm,
  output logic                 outVld,
  output logic signed [DW-1:0] outI,
  output logic signed [DW-1:0] outQ
);
  localparam int NTAPS = L + 1;
  localparam int NCOEF = NTAPS + (K/2 + 1) * (Q + 1);

  fmp_strb_t strb;

  fmp_ctrl #(.NTAPS(NTAPS), .NCOEF(NCOEF), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .inVld(inVld), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .strb(strb), .outVld(outVld)
  );

  fmp_datapath #(.DW(DW), .CW(CW), .CFRAC(CFRAC), .L(L), .Q(Q), .K(K), .AW(AW)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .cfgAddr(cfgAddr), .cfgRe(cfgRe), .cfgIm(cfgIm),
    .inI(inI), .inQ(inQ), .outI(outI), .outQ(outQ)
  );
endmodule

// File: rtl/fmp_checker.sv
module fmp_checker #(
  parameter int DW = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 inVld,
  input logic                 outVld,
  input logic signed [DW-1:0] outI,
  input logic signed [DW-1:0] outQ
);
  p_lat_fwd_r2: assert property (@(posedge clk) disable iff (rst)
    inVld |-> ##3 outVld);

  p_lat_bwd_r2: assert property (@(posedge clk) disable iff (rst)
    outVld |-> $past(inVld, 3));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !outVld |-> ($stable(outI) && $stable(outQ)));

  p_rst_clear_r1: assert property (@(posedge clk)
    rst |=> (!outVld && outI == '0 && outQ == '0));
endmodule

bind fmp_predistorter fmp_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .inVld(inVld), .outVld(outVld), .outI(outI), .outQ(outQ)
);

// File: tb/tb_fmp_predistorter.sv
module tb_fmp_predistorter;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12, CW = 16, CFR = 14, L = 2, Q = 2, K = 4, AW = 5;
  localparam int NT = L + 1, QD = Q + 1, NP = K/2 + 1;
  localparam int LAT = 3;
  localparam longint SMAX = 2047, SMIN = -2048;

  logic clk = 1'b0, rst = 1'b1, inVld = 1'b0, cfgWe = 1'b0;
  logic signed [DW-1:0] inI = '0, inQ = '0;
  logic [AW-1:0] cfgAddr = '0;
  logic signed [CW-1:0] cfgRe = '0, cfgIm = '0;
  logic outVld;
  logic signed [DW-1:0] outI, outQ;

  fmp_predistorter #(.DW(DW), .CW(CW), .CFRAC(CFR), .L(L), .Q(Q), .K(K), .AW(AW)) dut (
    .clk(clk), .rst(rst), .inVld(inVld), .inI(inI), .inQ(inQ), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgRe(cfgRe), .cfgIm(cfgIm), .outVld(outVld), .outI(outI), .outQ(outQ)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  longint hR[NT], hI[NT], aR[NP][QD], aI[NP][QD];
  longint mxI[NT], mxQ[NT], mbI[QD][NP], mbQ[QD][NP];

  // scoreboard
  int expI[$], expQ[$], expCyc[$];
  string expTag[$];

  function automatic longint rs(longint v, int sh);
    longint t = (v + (longint'(1) <<< (sh - 1))) >>> sh;
    if (t > SMAX) return SMAX;
    if (t < SMIN) return SMIN;
    return t;
  endfunction

  task automatic check(string req, longint act, longint exp, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int l = 0; l < NT; l++) begin
      hR[l] = (l == 0) ? 16384 : 0; hI[l] = 0; mxI[l] = 0; mxQ[l] = 0;
    end
    for (int j = 0; j < NP; j++)
      for (int q = 0; q < QD; q++) begin
        aR[j][q] = (j == 0 && q == 0) ? 16384 : 0; aI[j][q] = 0;
        mbI[q][j] = 0; mbQ[q][j] = 0;
      end
  endtask

  // R3 R4 R5 R6 computed from the stated formulas
  task automatic modelStep(int xi, int xq, output int oi, output int oq);
    longint accI, accQ, uI, uQ;
    longint p[NP];
    for (int l = NT - 1; l >= 1; l--) begin mxI[l] = mxI[l-1]; mxQ[l] = mxQ[l-1]; end
    mxI[0] = xi; mxQ[0] = xq;
    accI = 0; accQ = 0;
    for (int l = 0; l < NT; l++) begin
      accI += hR[l]*mxI[l] - hI[l]*mxQ[l];
      accQ += hR[l]*mxQ[l] + hI[l]*mxI[l];
    end
    uI = rs(accI, CFR); uQ = rs(accQ, CFR);
    p[0] = 0;
    p[1] = rs(uI*uI + uQ*uQ, DW-1);
    for (int j = 2; j < NP; j++) p[j] = rs(p[j-1]*p[1], DW-1);
    for (int q = QD - 1; q >= 1; q--)
      for (int j = 0; j < NP; j++) begin mbI[q][j] = mbI[q-1][j]; mbQ[q][j] = mbQ[q-1][j]; end
    mbI[0][0] = uI; mbQ[0][0] = uQ;
    for (int j = 1; j < NP; j++) begin
      mbI[0][j] = rs(uI*p[j], DW-1); mbQ[0][j] = rs(uQ*p[j], DW-1);
    end
    accI = 0; accQ = 0;
    for (int j = 0; j < NP; j++)
      for (int q = 0; q < QD; q++) begin
        accI += aR[j][q]*mbI[q][j] - aI[j][q]*mbQ[q][j];
        accQ += aR[j][q]*mbQ[q][j] + aI[j][q]*mbI[q][j];
      end
    oi = int'(rs(accI, CFR)); oq = int'(rs(accQ, CFR));
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic send(int xi, int xq, string tag);
    int oi, oq;
    inVld = 1'b1; inI = DW'(xi); inQ = DW'(xq);
    modelStep(xi, xq, oi, oq);
    expI.push_back(oi); expQ.push_back(oq); expCyc.push_back(cyc + LAT); expTag.push_back(tag);
    @(negedge clk);
    inVld = 1'b0;
  endtask

  // R7 address map: tap l at l, weight (k=2j, q) at NT + j*QD + q
  task automatic cfg(int addr, int re, int im);
    cfgWe = 1'b1; cfgAddr = AW'(addr); cfgRe = CW'(re); cfgIm = CW'(im);
    if (addr < NT) begin hR[addr] = re; hI[addr] = im; end
    else if (addr < NT + NP*QD) begin
      aR[(addr-NT)/QD][(addr-NT)%QD] = re; aI[(addr-NT)/QD][(addr-NT)%QD] = im;
    end
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic drain();
    repeat (LAT + 3) @(negedge clk);
  endtask

  task automatic randBurst(int n, int maxGap, string tag);
    for (int i = 0; i < n; i++) begin
      send(int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)) - 2048, tag);
      if (maxGap > 0) repeat (int'($urandom_range(0, maxGap))) @(negedge clk);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && outVld) begin
      if (expI.size() == 0) begin
        check("R2", 1, 0, "unexpected output strobe");
      end else begin
        int ei, eq, ec;
        string tg;
        ei = expI.pop_front(); eq = expQ.pop_front(); ec = expCyc.pop_front(); tg = expTag.pop_front();
        check("R2", cyc, ec, "output cycle");
        check(tg, int'(outI), ei, "outI");
        check(tg, int'(outQ), eq, "outQ");
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nFails++;
    $display("FAIL R2 watchdog: actual=hang expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(7));
    modelReset();
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1", outVld, 0, "outVld in reset");
    check("R1", outI, 0, "outI in reset");
    check("R1", outQ, 0, "outQ in reset");
    rst = 1'b0;
    @(negedge clk);

    // R1 identity after reset, including full-scale corners
    send(100, -200, "R1");
    send(2047, -2048, "R1");
    send(-2048, 2047, "R1");
    send(0, 0, "R1");
    randBurst(10, 0, "R1");
    drain();

    // R3 R8 linear prefilter only, back to back and with gaps
    cfg(0, 12288, 0);
    cfg(1, -2000, 3000);
    cfg(2, 500, -800);
    randBurst(20, 0, "R3");
    randBurst(20, 3, "R3");
    drain();

    // R9 R4 R5 unit prefilter, plain memory polynomial
    cfg(0, 16384, 0);
    cfg(1, 0, 0);
    cfg(2, 0, 0);
    cfg(NT + 1*QD + 0, -3000, 1500);   // k=2, q=0
    cfg(NT + 2*QD + 0, 2000, -500);    // k=4, q=0
    cfg(NT + 0*QD + 1, 800, -400);     // k=0, q=1
    cfg(NT + 1*QD + 2, 1200, 900);     // k=2, q=2
    send(2047, 2047, "R9");
    send(-1500, 600, "R4");
    randBurst(20, 2, "R9");
    drain();

    // R5 R3 full cascade with gaps between samples
    cfg(0, 15000, 800);
    cfg(1, -1200, 2200);
    cfg(2, 300, -600);
    cfg(NT + 2*QD + 1, -700, 300);
    randBurst(30, 4, "R5");
    drain();

    // R6 saturation at full scale
    cfg(0, 16384, 0); cfg(1, 0, 0); cfg(2, 0, 0);
    cfg(NT + 0*QD + 0, 32767, 32767);
    send(2047, -2047, "R6");
    send(2047, 2047, "R6");
    send(-2048, -2048, "R6");
    send(-2048, 2047, "R6");
    randBurst(10, 1, "R6");
    drain();

    // R7 unmapped addresses leave every coefficient unchanged
    cfg(NT + NP*QD, 9999, -9999);
    cfg(31, -7777, 7777);
    cfg(NT + NP*QD + 5, 1234, 4321);
    randBurst(12, 1, "R7");
    drain();

    check("R2", expI.size(), 0, "outstanding expected outputs");
    summary();
    $finish;
  end
endmodule